// File: doc/BRIEF.md
# Bit-Banged Serial Flash Pin Port

This block lets a host processor drive an external serial flash one pin at a time through a small 32-bit register port. The same four flash pins are normally driven by an internal automatic flash controller. The host must first claim the pins with a request bit and wait for a grant. While the grant is held, the clock, select and data-out levels on the pins follow bits that the host writes. While the grant is low, the pins follow the internal controller.

A separate control register holds a two-bit write-enable code. While that code says writes are disabled, the block watches the first byte that the host shifts after lowering chip select. If that byte is a write or erase opcode, the block stops the eighth clock edge from reaching the flash and forces chip select inactive. The flash therefore never accepts the command. A sticky error bit records that the block stepped in.

Top module: `flash_pin_port`

## Requirements
- R1: After reset the access register (byte address 4) reads CS (bit 1) as 1 and every other bit as 0, given an idle controller. The control register (byte address 0) reads 0x10, which is write-enable code 01 (disabled) in bits 5:4. The yield output is low.
- R2: The grant bit (bit 5 of the access register) rises only on the clock after the request bit (bit 4) is 1 and the controller's busy input is low. It stays high while the request bit stays 1, even if busy returns. It is low again on the second clock after a write clears the request bit. The yield output equals the request bit.
- R3: While the grant is low, the pins copy the controller's clock, select and data inputs, one clock later. The host's pin bits have no effect on the pins, and CS reads back as 1.
- R4: While the grant is high, one clock after a write the pins show the written bits: SCK is bit 0, CS is bit 1 (1 drives the select pin high, which is inactive), and SI is bit 2.
- R5: The access register reads bit 3 as the level on the flash data-in pin and bit 30 as the controller's busy input.
- R6: Writes leave the read-only bits (3, 5, 30, 31) of the access register unchanged. Unused bits of both registers read as 0.
- R7: Writing 01 or 10 to bits 5:4 of the control register makes that code take effect. 10 means writes are enabled. Reads return the code in effect.
- R8: A write of 00 or 11 to bits 5:4 of the control register is ignored, and the previous code is kept.
- R9: While the code is 01 and the grant is held, consider the first byte that the host shifts after lowering CS, MSB first, with SI sampled at each rising SCK bit. If that byte is 06h, 02h, D8h, 20h or C7h, the eighth rising SCK is not passed to the pin. The select pin is then held high until the host writes CS=1 or the grant ends. The error bit (bit 31) is set.
- R10: The error bit stays set until a write to the access register has the request bit at 0.
- R11: Any opcode outside that list is passed through whole while writes are disabled, and a listed opcode is passed through whole while writes are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data valid the clock after |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fl_sck | output | 1 | Flash clock pin |
| fl_cs_n | output | 1 | Flash select pin, active low |
| fl_mosi | output | 1 | Data toward the flash |
| fl_miso | input | 1 | Data from the flash |
| ctl_busy | input | 1 | Internal controller is mid-operation |
| ctl_sck | input | 1 | Controller's clock level |
| ctl_cs_n | input | 1 | Controller's select level |
| ctl_mosi | input | 1 | Controller's data level |
| ctl_yield | output | 1 | Asks the controller to give up the pins |

## Verification
The assertions assume that reset is held from the start and that the controller's busy input is a plain level, sampled each clock. They also assume that the host writes and reads no more than one register per clock. They treat an opcode as the SI level that comes with each written 0-to-1 change of the SCK bit while CS is low. The stimulus keeps within these limits. It applies one access at a time and leaves an idle cycle after each write. It changes SCK and SI in separate writes, so each bit is set up before its rising edge. It claims the pins only while the stub controller is idle or has already been granted.

// File: rtl/flash_port_pkg.sv
package flash_port_pkg;
  localparam int ACC_SCK = 0;
  localparam int ACC_CS  = 1;
  localparam int ACC_SI  = 2;
  localparam int ACC_SO  = 3;
  localparam int ACC_REQ = 4;
  localparam int ACC_GNT = 5;
  localparam int ACC_BSY = 30;
  localparam int ACC_ERR = 31;
  localparam int WEN_LO  = 4;
  localparam logic [1:0] WEN_OFF = 2'b01;
  localparam logic [1:0] WEN_ON  = 2'b10;
  localparam int OPC_W   = 8;

  typedef struct packed {
    logic sck;
    logic cs_n;
    logic mosi;
  } pin_t;

  function automatic logic is_guarded_op(input logic [OPC_W-1:0] op);
    case (op)
      8'h06, 8'h02, 8'hD8, 8'h20, 8'hC7: is_guarded_op = 1'b1;
      default:                           is_guarded_op = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fp_arbiter.sv
module fp_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic busy_i,
  output logic gnt_o,
  output logic yield_o
);
  logic gnt_q;

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= 1'b0;
    else     gnt_q <= req_i & (gnt_q | ~busy_i);
  end

  assign gnt_o   = gnt_q;
  assign yield_o = req_i;

  assert_gnt_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_q) |-> ($past(req_i) && !$past(busy_i)));
  assert_gnt_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !gnt_q);
endmodule

// File: rtl/fp_wen_reg.sv
module fp_wen_reg
  import flash_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [1:0] code_i,
  output logic [1:0] code_o,
  output logic       dis_o
);
  logic [1:0] code_q;
  logic       legal;

  assign legal = (code_i == WEN_OFF) || (code_i == WEN_ON);

  always_ff @(posedge clk) begin
    if (rst)                code_q <= WEN_OFF;
    else if (wr_i && legal) code_q <= code_i;
  end

  assign code_o = code_q;
  assign dis_o  = (code_q != WEN_ON);

  assert_wen_legal_R7: assert property (@(posedge clk) disable iff (rst)
    (code_q == WEN_OFF) || (code_q == WEN_ON));
  assert_wen_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (code_i[1] == code_i[0])) |=> $stable(code_q));
endmodule

// File: rtl/fp_op_guard.sv
module fp_op_guard
  import flash_port_pkg::*;
#(
  parameter int W = OPC_W
) (
  input  logic clk,
  input  logic rst,
  input  logic own_i,
  input  logic wr_i,
  input  logic cur_sck_i,
  input  logic new_sck_i,
  input  logic new_cs_i,
  input  logic new_si_i,
  input  logic wr_dis_i,
  output logic blk_o,
  output logic hit_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sh_q;
  logic          blk_q;
  logic          rise;
  logic [W-1:0]  byte_now;

  assign rise     = wr_i && !new_cs_i && !cur_sck_i && new_sck_i && (cnt_q != FULL);
  assign byte_now = {sh_q, new_si_i};
  assign hit_o    = own_i && rise && (cnt_q == LAST) && wr_dis_i && is_guarded_op(byte_now);

  always_ff @(posedge clk) begin
    if (rst || !own_i || (wr_i && new_cs_i)) begin
      cnt_q <= '0;
      sh_q  <= '0;
      blk_q <= 1'b0;
    end else if (rise) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= byte_now[W-2:0];
      if (hit_o) blk_q <= 1'b1;
    end
  end

  assign blk_o = blk_q;

  assert_block_needs_disable_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(blk_q) |-> ($past(wr_dis_i) && $past(own_i)));
endmodule

// File: rtl/fp_pin_mux.sv
module fp_pin_mux
  import flash_port_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic own_i,
  input  logic blk_i,
  input  pin_t host_i,
  input  pin_t ctl_i,
  output pin_t pins_o
);
  pin_t pins_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0};
    end else if (own_i) begin
      pins_q.sck  <= host_i.sck & ~blk_i;
      pins_q.cs_n <= host_i.cs_n | blk_i;
      pins_q.mosi <= host_i.mosi;
    end else begin
      pins_q <= ctl_i;
    end
  end

  assign pins_o = pins_q;

  assert_ctl_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    !own_i |=> (pins_q.sck == $past(ctl_i.sck)) && (pins_q.cs_n == $past(ctl_i.cs_n)));
endmodule

// File: rtl/flash_pin_port.sv
module flash_pin_port
  import flash_port_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CTL_ADDR = 0,
  parameter int ACC_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fl_sck,
  output logic              fl_cs_n,
  output logic              fl_mosi,
  input  logic              fl_miso,
  input  logic              ctl_busy,
  input  logic              ctl_sck,
  input  logic              ctl_cs_n,
  input  logic              ctl_mosi,
  output logic              ctl_yield
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_ACC = ADDR_W'(ACC_ADDR);

  logic wr_acc, wr_ctl;
  logic h_sck, h_cs, h_si, h_req, err_q;
  logic gnt, blk, hit, wr_dis;
  logic [1:0] wen_code;
  logic [DATA_W-1:0] acc_word, ctl_word, rdata_q;
  pin_t host_pins, ctl_pins, pins;

  assign wr_acc = bus_wr && (bus_addr == A_ACC);
  assign wr_ctl = bus_wr && (bus_addr == A_CTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_sck <= 1'b0;
      h_cs  <= 1'b1;
      h_si  <= 1'b0;
      h_req <= 1'b0;
    end else if (wr_acc) begin
      h_sck <= bus_wdata[ACC_SCK];
      h_cs  <= bus_wdata[ACC_CS];
      h_si  <= bus_wdata[ACC_SI];
      h_req <= bus_wdata[ACC_REQ];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               err_q <= 1'b0;
    else if (hit)                          err_q <= 1'b1;
    else if (wr_acc && !bus_wdata[ACC_REQ]) err_q <= 1'b0;
  end

  fp_arbiter u_arb (
    .clk(clk), .rst(rst), .req_i(h_req), .busy_i(ctl_busy),
    .gnt_o(gnt), .yield_o(ctl_yield)
  );

  fp_wen_reg u_wen (
    .clk(clk), .rst(rst), .wr_i(wr_ctl),
    .code_i(bus_wdata[WEN_LO+1:WEN_LO]), .code_o(wen_code), .dis_o(wr_dis)
  );

  fp_op_guard #(.W(OPC_W)) u_guard (
    .clk(clk), .rst(rst), .own_i(gnt), .wr_i(wr_acc),
    .cur_sck_i(h_sck), .new_sck_i(bus_wdata[ACC_SCK]),
    .new_cs_i(bus_wdata[ACC_CS]), .new_si_i(bus_wdata[ACC_SI]),
    .wr_dis_i(wr_dis), .blk_o(blk), .hit_o(hit)
  );

  assign host_pins = '{sck: h_sck, cs_n: h_cs, mosi: h_si};
  assign ctl_pins  = '{sck: ctl_sck, cs_n: ctl_cs_n, mosi: ctl_mosi};

  fp_pin_mux u_mux (
    .clk(clk), .rst(rst), .own_i(gnt), .blk_i(blk),
    .host_i(host_pins), .ctl_i(ctl_pins), .pins_o(pins)
  );

  assign fl_sck  = pins.sck;
  assign fl_cs_n = pins.cs_n;
  assign fl_mosi = pins.mosi;

  always_comb begin
    acc_word          = '0;
    acc_word[ACC_SCK] = h_sck;
    acc_word[ACC_CS]  = gnt ? h_cs : 1'b1;
    acc_word[ACC_SI]  = h_si;
    acc_word[ACC_SO]  = fl_miso;
    acc_word[ACC_REQ] = h_req;
    acc_word[ACC_GNT] = gnt;
    acc_word[ACC_BSY] = ctl_busy;
    acc_word[ACC_ERR] = err_q;
    ctl_word          = '0;
    ctl_word[WEN_LO+1:WEN_LO] = wen_code;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      if (bus_addr == A_ACC)      rdata_q <= acc_word;
      else if (bus_addr == A_CTL) rdata_q <= ctl_word;
      else                        rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[DATA_W-1:WEN_LO+2], bus_wdata[ACC_SO]};

  assert_block_forces_pins_R9: assert property (@(posedge clk) disable iff (rst)
    (blk && gnt) |=> (fl_cs_n && !fl_sck));
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> ($past(wr_acc) && !$past(bus_wdata[ACC_REQ])));
  assert_host_pins_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt && !blk) |=> (fl_mosi == $past(h_si)));
endmodule

// File: tb/test_flash_pin_port.sv
`timescale 1ns/1ps
module test_flash_pin_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fl_sck, fl_cs_n, fl_mosi;
  logic        fl_miso = 1'b0;
  logic        ctl_busy = 1'b0, ctl_sck = 1'b0, ctl_cs_n = 1'b1, ctl_mosi = 1'b0;
  logic        ctl_yield;

  always #4 clk = ~clk;

  flash_pin_port i_flash_pin_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fl_sck(fl_sck), .fl_cs_n(fl_cs_n), .fl_mosi(fl_mosi), .fl_miso(fl_miso),
    .ctl_busy(ctl_busy), .ctl_sck(ctl_sck), .ctl_cs_n(ctl_cs_n), .ctl_mosi(ctl_mosi),
    .ctl_yield(ctl_yield)
  );

  typedef struct {
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic rd_seen = 1'b0;
  bit   done = 0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      n_cmp++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: got %h expected an entry", bus_rdata);
      end else begin
        e = sb.pop_front();
        if ((bus_rdata & e.mask) !== e.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", e.tag, bus_rdata & e.mask, e.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] m, input logic [31:0] x, input string tag);
    exp_t e;
    e.mask = m; e.exp = x & m; e.tag = tag;
    sb.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic got, input logic want);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, want);
    end
  endtask

  task automatic acc(input logic sck, input logic cs, input logic si, input logic req);
    wr(4'h4, {27'b0, req, 1'b0, si, cs, sck});
  endtask

  task automatic send_check(input logic [7:0] op, input logic blocked, input string tag);
    acc(0, 0, 0, 1);
    chk({tag, " cs low"}, fl_cs_n, 1'b0);
    for (int i = 7; i >= 1; i--) begin
      acc(0, 0, op[i], 1);
      acc(1, 0, op[i], 1);
    end
    chk({tag, " seventh edge passed"}, fl_sck, 1'b1);
    acc(0, 0, op[0], 1);
    acc(1, 0, op[0], 1);
    chk({tag, " eighth sck pin"}, fl_sck, !blocked);
    chk({tag, " eighth cs pin"}, fl_cs_n, blocked);
    acc(0, 1, 0, 1);
    chk({tag, " cs released"}, fl_cs_n, 1'b1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd(4'h4, 32'hFFFF_FFFF, 32'h0000_0002, "R1 access reset");
    rd(4'h0, 32'hFFFF_FFFF, 32'h0000_0010, "R1 control reset");
    chk("R1 yield low", ctl_yield, 1'b0);

    // R3 controller owns the pins
    ctl_sck = 1; ctl_cs_n = 0; ctl_mosi = 1;
    acc(0, 0, 0, 0);
    idle(1);
    chk("R3 sck follows ctl", fl_sck, 1'b1);
    chk("R3 cs follows ctl", fl_cs_n, 1'b0);
    chk("R3 mosi follows ctl", fl_mosi, 1'b1);
    rd(4'h4, 32'h7, 32'h2, "R3 cs reads inactive");
    ctl_sck = 0; ctl_cs_n = 1; ctl_mosi = 0;
    idle(2);
    chk("R3 sck follows ctl 2", fl_sck, 1'b0);
    chk("R3 cs follows ctl 2", fl_cs_n, 1'b1);

    // R5 live inputs
    fl_miso = 1;
    rd(4'h4, 32'h8, 32'h8, "R5 so high");
    fl_miso = 0; ctl_busy = 1;
    rd(4'h4, 32'h4000_0008, 32'h4000_0000, "R5 busy high so low");

    // R2 handshake
    acc(0, 1, 0, 1);
    idle(2);
    chk("R2 yield follows req", ctl_yield, 1'b1);
    rd(4'h4, 32'h20, 32'h0, "R2 no grant while busy");
    ctl_busy = 0;
    idle(2);
    rd(4'h4, 32'h20, 32'h20, "R2 grant when idle");
    ctl_busy = 1;
    idle(2);
    rd(4'h4, 32'h20, 32'h20, "R2 grant held");

    // R4 host drives pins
    acc(1, 1, 0, 1);
    chk("R4 sck host", fl_sck, 1'b1);
    chk("R4 cs host", fl_cs_n, 1'b1);
    chk("R4 mosi host", fl_mosi, 1'b0);
    acc(0, 0, 1, 1);
    chk("R4 sck host 2", fl_sck, 1'b0);
    chk("R4 cs host 2", fl_cs_n, 1'b0);
    chk("R4 mosi host 2", fl_mosi, 1'b1);
    rd(4'h4, 32'h3F, 32'h34, "R4 readback");

    // R6 read-only bits
    wr(4'h4, 32'hC000_003A);
    rd(4'h4, 32'hFFFF_FFFF, 32'h4000_0032, "R6 read-only bits kept");
    ctl_busy = 0;

    // R7 / R8 write-enable code
    wr(4'h0, 32'h0000_0020);
    rd(4'h0, 32'hFFFF_FFFF, 32'h20, "R7 enable code");
    wr(4'h0, 32'h0000_0000);
    rd(4'h0, 32'hFFFF_FFFF, 32'h20, "R8 code 00 ignored");
    wr(4'h0, 32'h0000_0030);
    rd(4'h0, 32'hFFFF_FFFF, 32'h20, "R8 code 11 ignored");
    wr(4'h0, 32'h0000_0010);
    rd(4'h0, 32'hFFFF_FFFF, 32'h10, "R7 disable code");
    wr(4'h0, 32'hFFFF_FFCF);
    rd(4'h0, 32'hFFFF_FFFF, 32'h10, "R8 code 00 with noise ignored");

    // R9 / R11 opcode gating
    send_check(8'h06, 1'b1, "R9 06h blocked");
    rd(4'h4, 32'h8000_0000, 32'h8000_0000, "R9 error set");
    send_check(8'h03, 1'b0, "R11 03h passes");
    send_check(8'hC7, 1'b1, "R9 C7h blocked");
    send_check(8'hD8, 1'b1, "R9 D8h blocked");
    wr(4'h0, 32'h0000_0020);
    send_check(8'h02, 1'b0, "R11 02h passes enabled");
    send_check(8'h20, 1'b0, "R11 20h passes enabled");

    // R10 sticky error
    rd(4'h4, 32'h8000_0000, 32'h8000_0000, "R10 error sticky");
    acc(0, 1, 0, 0);
    rd(4'h4, 32'h8000_0020, 32'h0, "R10 error cleared and R2 grant dropped");
    chk("R2 yield low", ctl_yield, 1'b0);

    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule